// File: doc/BRIEF.md
# I2C Master Address Sequencer with Arbitration

This block is the master-side front end of a two-wire serial bus controller. It handles only the addressing phase of a transfer. On command it generates a start or repeated-start condition and shifts an address byte out most significant bit first. It then releases the data line for the ninth clock, samples the target's acknowledge, and derives the transfer direction from the byte it sent. A stop command ends the transfer. A separate command sends a second address byte without a new start, which is needed for 10-bit targets. Software composes every byte, so 7-bit and 10-bit addressing both come down to sequences of the same commands.

The block watches the bus while it drives it. If it releases the data line for a 1 but sees the line low during the clock-high half of an address bit, another master has won. The same happens if a start it tries to generate cannot be made, or if a start appears on the bus at the first bit of a byte it is sending. In each case it raises a sticky arbitration-lost flag, drops its master and transmit state, and lets go of both lines at once, which leaves it a passive slave. It stays passive until a stop is seen on the bus.

Bus timing comes from `bitTick`, a one-cycle enable that steps each bit through four phases: clock low with data set up, clock released, clock high with sampling, and clock low again. Successive ticks must be at least four clock cycles apart. The line outputs are registered pull-down enables, and the sampled bus levels come back on `sdaIn` and `sclIn`.

Top module: `i2c_addr_master`

## Requirements
- R1: After reset both pull-down enables are 0 and busBusy, isMaster, isTx, lastRxBit and arbLost are all 0.
- R2: A cmdStart on an idle, free bus produces a start condition (SDA falls while SCL is high) and sets busBusy, isMaster and isTx to 1. The byte on addrByte is then sent in eight SCL pulses, MSB first, and SDA is released for a ninth pulse.
- R3: The SDA level sampled while SCL is high on the ninth pulse is stored in lastRxBit, where 0 means acknowledged and 1 means not acknowledged.
- R4: When the first byte after a start or repeated start is acknowledged, isTx becomes the inverse of that byte's bit 0. A byte that is not acknowledged leaves isTx unchanged, and so does a byte sent by cmdSendAddr.
- R5: The sequence cmdStart(11110 A9 A8 0), cmdSendAddr(A7..A0), cmdRestart(11110 A9 A8 1) puts exactly these three bytes on the bus, with a repeated start before the third, and ends with isTx = 0.
- R6: busBusy stays 1 for the whole of a repeated start. A cmdStop produces a stop condition (SDA rises while SCL is high), after which busBusy, isMaster and isTx are 0 and both lines are released.
- R7: Outside start, repeated-start and stop conditions, SDA changes only while SCL is low. A start, restart, stop sequence therefore shows exactly two start events and one stop event on the bus.
- R8: If the block releases SDA for a 1 during an address bit but samples SDA low while SCL is high, it sets arbLost, clears isMaster and isTx, and releases both lines within that byte. It stays passive until a stop appears on the bus, after which busBusy is 0.
- R9: Arbitration is not checked on the ninth (acknowledge) pulse, so a target pulling SDA low there leaves arbLost at 0.
- R10: A cmdStart while busBusy is 1 because another master has started fails at once: arbLost is set, isMaster stays 0, and neither line is driven.
- R11: cmdSendAddr, cmdStop and cmdRestart are ignored while idle: no line is driven and no flag changes.
- R12: An accepted cmdStart clears arbLost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | Bit-phase step enable, at least 4 cycles apart |
| cmdStart | input | 1 | Generate start and send addrByte |
| cmdRestart | input | 1 | Generate repeated start and send addrByte |
| cmdStop | input | 1 | Generate stop condition |
| cmdSendAddr | input | 1 | Send addrByte without a new start |
| addrByte | input | BYTE_W | Byte to send |
| sdaIn | input | 1 | Sampled data line level |
| sclIn | input | 1 | Sampled clock line level |
| sdaOe | output | 1 | Pull data line low |
| sclOe | output | 1 | Pull clock line low |
| busBusy | output | 1 | Bus occupied between a start and a stop |
| isMaster | output | 1 | Block owns the bus |
| isTx | output | 1 | Block is transmitter |
| lastRxBit | output | 1 | Last acknowledge level sampled |
| arbLost | output | 1 | Sticky arbitration-lost flag |

## Verification
The bench drives a wired-AND bus with a target that can acknowledge and a competing master that pulls SDA low at a chosen bit. It decodes every SCL pulse and every start and stop event, so a design that moves SDA while SCL is high shows extra events, and a design that shifts LSB first or sends a stray bit returns the wrong bytes. The 10-bit case uses a low byte whose bit 0 is 1: a design that applies the direction rule to every acknowledged byte instead of only the first after a start would clear isTx there. An acknowledge that pulls SDA low catches a design that checks arbitration on the ninth pulse. Starting on a bus already held by another master catches a design that tries to drive the bus anyway.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;

  // Four phases per bit: low/setup, release, high/sample, low again
  localparam int PHASES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SHIFT,
    ST_HOLD,
    ST_RESTART,
    ST_STOP,
    ST_SLAVE
  } seqState_t;

  typedef enum logic [1:0] {
    SDA_REL  = 2'd0,
    SDA_LOW  = 2'd1,
    SDA_DATA = 2'd2
  } sdaMode_t;

  typedef struct packed {
    logic     loadByte;
    logic     shiftBit;
    logic     captureAck;
    logic     setDir;
    logic     beginMaster;
    logic     freshStart;
    logic     loseArb;
    logic     endMaster;
    logic     sclLow;
    sdaMode_t sdaMode;
  } seqStrobe_t;

endpackage

// File: rtl/addr_seq_ctrl.sv
module addr_seq_ctrl
  import addr_seq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       cmdStart,
  input  logic       cmdRestart,
  input  logic       cmdStop,
  input  logic       cmdSendAddr,
  input  logic       sdaIn,
  input  logic       sclIn,
  input  logic       sendBit,
  input  logic       startSeen,
  input  logic       busBusy,
  output seqStrobe_t stb
);

  localparam int PH_W  = $clog2(PHASES);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(BYTE_W);
  localparam logic [PH_W-1:0]  PH0 = PH_W'(0);
  localparam logic [PH_W-1:0]  PH1 = PH_W'(1);
  localparam logic [PH_W-1:0]  PH2 = PH_W'(2);
  localparam logic [PH_W-1:0]  PH3 = PH_W'(3);

  seqState_t        state, nState;
  logic [PH_W-1:0]  phase, nPhase;
  logic [CNT_W-1:0] bitIdx, nBit;
  logic             firstByte, nFirst;
  logic             lose;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= PH0;
      bitIdx    <= '0;
      firstByte <= 1'b0;
    end else begin
      state     <= nState;
      phase     <= nPhase;
      bitIdx    <= nBit;
      firstByte <= nFirst;
    end
  end

  always_comb begin
    stb    = '0;
    nState = state;
    nPhase = phase;
    nBit   = bitIdx;
    nFirst = firstByte;
    lose   = 1'b0;

    // line levels for the current phase
    case (state)
      ST_START: begin
        stb.sdaMode = (phase == PH0) ? SDA_REL : SDA_LOW;
        stb.sclLow  = (phase == PH2);
      end
      ST_SHIFT: begin
        stb.sdaMode = (bitIdx == ACK_IDX) ? SDA_REL : SDA_DATA;
        stb.sclLow  = (phase == PH0) || (phase == PH3);
      end
      ST_HOLD: stb.sclLow = 1'b1;
      ST_RESTART: begin
        stb.sdaMode = (phase == PH2 || phase == PH3) ? SDA_LOW : SDA_REL;
        stb.sclLow  = (phase == PH0) || (phase == PH3);
      end
      ST_STOP: begin
        stb.sdaMode = (phase == PH0 || phase == PH1) ? SDA_LOW : SDA_REL;
        stb.sclLow  = (phase == PH0);
      end
      default: ;
    endcase

    // sequencing
    case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          if (busBusy || !sdaIn || !sclIn) begin
            lose = 1'b1;
          end else begin
            stb.loadByte    = 1'b1;
            stb.beginMaster = 1'b1;
            stb.freshStart  = 1'b1;
            nState = ST_START;
            nPhase = PH0;
            nFirst = 1'b1;
          end
        end
      end
      ST_START: begin
        if (bitTick) begin
          if (phase == PH0) begin
            if (!sdaIn || !sclIn) lose = 1'b1;
            else nPhase = PH1;
          end else if (phase == PH1) begin
            nPhase = PH2;
          end else begin
            nState = ST_SHIFT;
            nPhase = PH0;
            nBit   = '0;
          end
        end
      end
      ST_SHIFT: begin
        if (startSeen && bitIdx == '0 && phase != PH0) begin
          lose = 1'b1;  // someone else started on our first bit
        end else if (bitTick) begin
          case (phase)
            PH0: nPhase = PH1;
            PH1: nPhase = PH2;
            PH2: begin
              if (bitIdx != ACK_IDX) begin
                if (sendBit && !sdaIn) lose = 1'b1;
              end else begin
                stb.captureAck = 1'b1;
              end
              nPhase = PH3;
            end
            default: begin
              nPhase = PH0;
              if (bitIdx == ACK_IDX) begin
                stb.setDir = firstByte;
                nFirst = 1'b0;
                nState = ST_HOLD;
              end else begin
                stb.shiftBit = 1'b1;
                nBit = bitIdx + 1'b1;
              end
            end
          endcase
        end
      end
      ST_HOLD: begin
        if (cmdRestart) begin
          stb.loadByte    = 1'b1;
          stb.beginMaster = 1'b1;
          nState = ST_RESTART;
          nPhase = PH0;
          nFirst = 1'b1;
        end else if (cmdStop) begin
          nState = ST_STOP;
          nPhase = PH0;
        end else if (cmdSendAddr) begin
          stb.loadByte = 1'b1;
          nState = ST_SHIFT;
          nPhase = PH0;
          nBit   = '0;
        end
      end
      ST_RESTART: begin
        if (bitTick) begin
          case (phase)
            PH0: nPhase = PH1;
            PH1: begin
              if (!sdaIn || !sclIn) lose = 1'b1;
              else nPhase = PH2;
            end
            PH2: nPhase = PH3;
            default: begin
              nState = ST_SHIFT;
              nPhase = PH0;
              nBit   = '0;
            end
          endcase
        end
      end
      ST_STOP: begin
        if (bitTick) begin
          if (phase == PH2) begin
            if (!sdaIn) begin
              lose = 1'b1;
            end else begin
              stb.endMaster = 1'b1;
              nState = ST_IDLE;
              nPhase = PH0;
            end
          end else begin
            nPhase = phase + 1'b1;
          end
        end
      end
      default: begin  // ST_SLAVE: passive until the bus is free
        if (!busBusy) begin
          nState = ST_IDLE;
          nPhase = PH0;
        end
      end
    endcase

    if (lose) begin
      stb          = '0;
      stb.loseArb  = 1'b1;
      nState       = ST_SLAVE;
      nPhase       = PH0;
    end
  end

  // R6
  restart_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESTART) |-> busBusy);

  // R8
  slave_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loseArb |=> (state == ST_SLAVE));

endmodule

// File: rtl/addr_seq_dp.sv
module addr_seq_dp
  import addr_seq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [BYTE_W-1:0] addrByte,
  input  logic              sdaIn,
  input  logic              sclIn,
  output logic              sendBit,
  output logic              startSeen,
  output logic              sdaOe,
  output logic              sclOe,
  output logic              busBusy,
  output logic              isMaster,
  output logic              isTx,
  output logic              lastRxBit,
  output logic              arbLost
);

  logic [BYTE_W-1:0] shReg;
  logic              sentLsb;
  logic              sdaPrev, sclPrev;
  logic              stopSeen;

  assign sendBit   = shReg[BYTE_W-1];
  assign startSeen = sclPrev && sclIn && sdaPrev && !sdaIn;
  assign stopSeen  = sclPrev && sclIn && !sdaPrev && sdaIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      sentLsb   <= 1'b0;
      sdaPrev   <= 1'b1;
      sclPrev   <= 1'b1;
      sdaOe     <= 1'b0;
      sclOe     <= 1'b0;
      busBusy   <= 1'b0;
      isMaster  <= 1'b0;
      isTx      <= 1'b0;
      lastRxBit <= 1'b0;
      arbLost   <= 1'b0;
    end else begin
      sdaPrev <= sdaIn;
      sclPrev <= sclIn;
      sclOe   <= stb.sclLow;
      sdaOe   <= (stb.sdaMode == SDA_LOW) ||
                 ((stb.sdaMode == SDA_DATA) && !shReg[BYTE_W-1]);

      if (stb.loadByte) begin
        shReg   <= addrByte;
        sentLsb <= addrByte[0];
      end else if (stb.shiftBit) begin
        shReg <= {shReg[BYTE_W-2:0], 1'b0};
      end

      if (stb.captureAck) lastRxBit <= sdaIn;

      if (stopSeen) busBusy <= 1'b0;
      else if (startSeen || stb.beginMaster) busBusy <= 1'b1;

      if (stb.loseArb || stb.endMaster) begin
        isMaster <= 1'b0;
        isTx     <= 1'b0;
      end else if (stb.beginMaster) begin
        isMaster <= 1'b1;
        isTx     <= 1'b1;
      end else if (stb.setDir && !lastRxBit) begin
        isTx <= !sentLsb;
      end

      if (stb.loseArb) arbLost <= 1'b1;
      else if (stb.freshStart) arbLost <= 1'b0;
    end
  end

  // R7
  shift_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftBit |-> sclOe);

  // R6
  stop_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !busBusy);

  // R2
  begin_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.beginMaster |=> (isMaster && isTx && busBusy));

  // R8
  lost_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> (!isMaster && !isTx));

endmodule

// File: rtl/i2c_addr_master.sv
module i2c_addr_master
  import addr_seq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              cmdStart,
  input  logic              cmdRestart,
  input  logic              cmdStop,
  input  logic              cmdSendAddr,
  input  logic [BYTE_W-1:0] addrByte,
  input  logic              sdaIn,
  input  logic              sclIn,
  output logic              sdaOe,
  output logic              sclOe,
  output logic              busBusy,
  output logic              isMaster,
  output logic              isTx,
  output logic              lastRxBit,
  output logic              arbLost
);

  seqStrobe_t stb;
  logic       sendBit;
  logic       startSeen;

  addr_seq_ctrl #(.BYTE_W(BYTE_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitTick    (bitTick),
    .cmdStart   (cmdStart),
    .cmdRestart (cmdRestart),
    .cmdStop    (cmdStop),
    .cmdSendAddr(cmdSendAddr),
    .sdaIn      (sdaIn),
    .sclIn      (sclIn),
    .sendBit    (sendBit),
    .startSeen  (startSeen),
    .busBusy    (busBusy),
    .stb        (stb)
  );

  addr_seq_dp #(.BYTE_W(BYTE_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .addrByte  (addrByte),
    .sdaIn     (sdaIn),
    .sclIn     (sclIn),
    .sendBit   (sendBit),
    .startSeen (startSeen),
    .sdaOe     (sdaOe),
    .sclOe     (sclOe),
    .busBusy   (busBusy),
    .isMaster  (isMaster),
    .isTx      (isTx),
    .lastRxBit (lastRxBit),
    .arbLost   (arbLost)
  );

endmodule

// File: tb/test_i2c_addr_master.sv
`timescale 1ns/1ps
module test_i2c_addr_master;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick;
  logic       cmdStart = 0, cmdRestart = 0, cmdStop = 0, cmdSendAddr = 0;
  logic [7:0] addrByte = 8'h00;
  logic       sdaIn, sclIn;
  logic       sdaOe, sclOe, busBusy, isMaster, isTx, lastRxBit, arbLost;

  // bus agents
  logic ackOn = 1'b0, ackPull = 1'b0, arbPull = 1'b0;
  logic manualSda = 1'b0, manualScl = 1'b0;
  int   arbAt = -1;

  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  logic [1:0] tickCnt = 2'd0;
  always @(posedge clk) tickCnt <= tickCnt + 2'd1;
  assign bitTick = (tickCnt == 2'd3);

  assign sclIn = !(sclOe || manualScl);
  assign sdaIn = !(sdaOe || ackPull || arbPull || manualSda);

  i2c_addr_master #(.BYTE_W(8)) i_i2c_addr_master (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .cmdStart(cmdStart), .cmdRestart(cmdRestart), .cmdStop(cmdStop),
    .cmdSendAddr(cmdSendAddr), .addrByte(addrByte),
    .sdaIn(sdaIn), .sclIn(sclIn), .sdaOe(sdaOe), .sclOe(sclOe),
    .busBusy(busBusy), .isMaster(isMaster), .isTx(isTx),
    .lastRxBit(lastRxBit), .arbLost(arbLost)
  );

  // behavioural bus observer: pulses, bits, start/stop events, target, rival
  logic prevScl = 1'b1, prevSda = 1'b1;
  int   pulseCnt = 0, startCnt = 0, stopCnt = 0, busyDrop = 0;
  logic busyWin = 1'b0;
  logic bitQ[$];

  always @(negedge clk) begin
    if (prevScl && sclIn && prevSda && !sdaIn) begin
      startCnt++;
      pulseCnt = 0;
      bitQ.delete();
    end
    if (prevScl && sclIn && !prevSda && sdaIn) stopCnt++;
    if (!prevScl && sclIn) begin
      pulseCnt++;
      bitQ.push_back(sdaIn);
    end
    if (prevScl && !sclIn) begin
      if (ackOn && pulseCnt > 0 && (pulseCnt % 9) == 8) ackPull = 1'b1;
      else if ((pulseCnt % 9) == 0) ackPull = 1'b0;
      if (arbAt >= 0) arbPull = (pulseCnt == arbAt);
    end
    if (arbAt < 0) arbPull = 1'b0;
    if (busyWin && !busBusy) busyDrop++;
    prevScl = sclIn;
    prevSda = sdaIn;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseCmd(input int which, input logic [7:0] b);
    @(negedge clk);
    addrByte = b;
    case (which)
      0: cmdStart = 1'b1;
      1: cmdRestart = 1'b1;
      2: cmdStop = 1'b1;
      default: cmdSendAddr = 1'b1;
    endcase
    @(negedge clk);
    cmdStart = 0; cmdRestart = 0; cmdStop = 0; cmdSendAddr = 0;
  endtask

  task automatic expectByte(input logic [7:0] exp, input string req);
    logic [7:0] got = 8'h00;
    if (bitQ.size() < 9) begin
      chk(req, "bits on bus", bitQ.size(), 9);
      bitQ.delete();
    end else begin
      for (int i = 0; i < 8; i++) got = {got[6:0], bitQ.pop_front()};
      void'(bitQ.pop_front());
      chk(req, "byte on bus", int'(got), int'(exp));
    end
  endtask

  task automatic busStop();
    manualScl = 1'b1;
    waitCyc(6);
    arbAt = -1;
    manualSda = 1'b1;
    waitCyc(6);
    manualScl = 1'b0;
    waitCyc(6);
    manualSda = 1'b0;
    waitCyc(10);
  endtask

  initial begin
    int s0, p0;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);
    // R1 reset state
    chk("R1", "sdaOe", sdaOe, 0);
    chk("R1", "sclOe", sclOe, 0);
    chk("R1", "flags", {busBusy, isMaster, isTx, lastRxBit, arbLost}, 0);

    // R11 commands ignored while idle
    pulseCmd(3, 8'h00);
    pulseCmd(2, 8'h00);
    pulseCmd(1, 8'h55);
    waitCyc(40);
    chk("R11", "lines", {sdaOe, sclOe}, 0);
    chk("R11", "flags", {busBusy, isMaster, isTx, arbLost}, 0);
    chk("R11", "bus starts", startCnt, 0);

    // 7-bit read-direction addressing with acknowledge, restart, stop
    ackOn = 1'b1;
    s0 = startCnt; p0 = stopCnt;
    pulseCmd(0, 8'hA0);
    waitCyc(6);
    chk("R2", "busBusy after start", busBusy, 1);
    chk("R2", "isMaster after start", isMaster, 1);
    chk("R2", "isTx after start", isTx, 1);
    waitCyc(200);
    expectByte(8'hA0, "R2");
    chk("R3", "lastRxBit ack", lastRxBit, 0);
    chk("R4", "isTx after 0xA0", isTx, 1);
    chk("R9", "arbLost after ack low", arbLost, 0);
    busyWin = 1'b1;
    pulseCmd(1, 8'hA1);
    waitCyc(220);
    busyWin = 1'b0;
    expectByte(8'hA1, "R2");
    chk("R4", "isTx after 0xA1", isTx, 0);
    chk("R6", "busBusy drops in restart", busyDrop, 0);
    pulseCmd(2, 8'h00);
    waitCyc(60);
    chk("R6", "flags after stop", {busBusy, isMaster, isTx}, 0);
    chk("R6", "lines after stop", {sdaOe, sclOe}, 0);
    chk("R7", "start events", startCnt - s0, 2);
    chk("R7", "stop events", stopCnt - p0, 1);

    // not acknowledged
    ackOn = 1'b0;
    pulseCmd(0, 8'h3B);
    waitCyc(200);
    expectByte(8'h3B, "R3");
    chk("R3", "lastRxBit nack", lastRxBit, 1);
    chk("R4", "isTx kept on nack", isTx, 1);
    pulseCmd(2, 8'h00);
    waitCyc(60);

    // 10-bit read of 0x2D5
    ackOn = 1'b1;
    s0 = startCnt; p0 = stopCnt;
    pulseCmd(0, 8'hF4);
    waitCyc(200);
    expectByte(8'hF4, "R5");
    chk("R4", "isTx after header write", isTx, 1);
    pulseCmd(3, 8'hD5);
    waitCyc(200);
    expectByte(8'hD5, "R5");
    chk("R4", "isTx kept after low byte", isTx, 1);
    pulseCmd(1, 8'hF5);
    waitCyc(220);
    expectByte(8'hF5, "R5");
    chk("R5", "isTx after header read", isTx, 0);
    pulseCmd(2, 8'h00);
    waitCyc(60);
    chk("R7", "10-bit start events", startCnt - s0, 2);
    chk("R7", "10-bit stop events", stopCnt - p0, 1);

    // arbitration lost on the third bit of 0xA4
    ackOn = 1'b0;
    arbAt = 2;
    pulseCmd(0, 8'hA4);
    waitCyc(200);
    chk("R8", "arbLost", arbLost, 1);
    chk("R8", "master/tx", {isMaster, isTx}, 0);
    chk("R8", "lines released", {sdaOe, sclOe}, 0);
    chk("R8", "busBusy held", busBusy, 1);
    busStop();
    chk("R8", "busBusy after rival stop", busBusy, 0);

    // fresh start clears the flag
    ackOn = 1'b1;
    pulseCmd(0, 8'hA0);
    waitCyc(6);
    chk("R12", "arbLost cleared", arbLost, 0);
    waitCyc(200);
    pulseCmd(2, 8'h00);
    waitCyc(60);

    // start on a bus held by another master
    manualSda = 1'b1;
    waitCyc(20);
    chk("R10", "busBusy from rival", busBusy, 1);
    pulseCmd(0, 8'hA0);
    waitCyc(10);
    chk("R10", "arbLost", arbLost, 1);
    chk("R10", "isMaster", isMaster, 0);
    chk("R10", "lines", {sdaOe, sclOe}, 0);
    busStop();
    chk("R10", "busBusy after stop", busBusy, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule